// File: doc/BRIEF.md
# Integer Compare Flag Unit

This block compares two integer operands by subtracting the second from the first. It returns a status word that carries the four condition flags: negative, zero, carry and overflow. Each operand arrives as a 64-bit register image. A per-request width select decides how the operands are read. In narrow mode only the low 32 bits of each operand are compared. In wide mode the full 64-bit values are compared.

The flags occupy the four most significant bits of the status word, and every other bit reads as zero. A request is marked by a valid strobe. The registered status and a matching valid strobe appear one clock later. Between requests the status output keeps its last value, so a core can read it at its leisure.

Top module: `cmp_flag_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `out_valid` low and `out_status` all zero, even if `in_valid` is high in that cycle.
- R2: `out_valid` is high in the cycle after a rising edge that sampled `in_valid` high, and low in the cycle after one that sampled it low.
- R3: Bits 27 to 0 of `out_status` are always zero.
- R4: Bit 30 (zero flag) is set when the difference at the selected width is zero.
- R5: Bit 31 (negative flag) equals the sign bit of the difference at the selected width.
- R6: Bit 28 (overflow flag) is set when the operands differ in sign and the difference's sign differs from the first operand's sign.
- R7: Bit 29 (carry flag) is set when (A negative and B non-negative), or (A negative and difference non-negative), or (B non-negative and difference non-negative). Signs are taken at the selected width, which means A is greater than or equal to B as unsigned numbers.
- R8: With `in_wide` = 0 the upper 32 bits of both operands have no effect on the flags. The compare uses bits 31..0, with bit 31 as the sign.
- R9: A rising edge with `in_valid` low leaves `out_status` unchanged, whatever the operands and mode are.
- R10: With `in_wide` = 1 the flags come from the full 64-bit difference, with bit 63 as the sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Compare request strobe |
| in_wide | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare on low halves |
| in_src_a | input | 64 | First operand (minuend) |
| in_src_b | input | 64 | Second operand (subtrahend) |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_status | output | 32 | Flags in bits 31..28 (N, Z, C, V), zeros below |

## Verification
Two functions can fall in the same cycle here. Presenting the previous result coincides with capturing a new request when requests come back to back. A reset can also arrive together with a request. The bench issues streams of back-to-back requests that flip the width select on every request. It also asserts reset in a cycle where `in_valid` is high. Every cycle is judged against a behavioural model. The model derives carry from an unsigned comparison and overflow from a sign-extended difference. The model must show the new flags after each back-to-back request and an all-zero idle output after the colliding reset.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;

  // Condition flags, most significant first (N, Z, C, V).
  typedef struct packed {
    logic neg;
    logic zero;
    logic carry;
    logic ovf;
  } cmpf_flags_t;

  localparam int CMPF_FLAG_W = 4;

  // Carry (no borrow) of a - b, from the three sign bits.
  function automatic logic cmpf_carry(input logic sa, input logic sb, input logic sr);
    return (sa & ~sb) | (sa & ~sr) | (~sb & ~sr);
  endfunction

  // Signed overflow of a - b, from the three sign bits.
  function automatic logic cmpf_ovf(input logic sa, input logic sb, input logic sr);
    return (sa & ~sb & ~sr) | (~sa & sb & sr);
  endfunction

endpackage

// File: rtl/cmpf_lane.sv
module cmpf_lane
  import cmpf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] lane_a,
  input  logic [W-1:0] lane_b,
  output cmpf_flags_t  lane_flags
);

  logic [W-1:0] diff;
  logic         sign_a, sign_b, sign_r;

  always_comb begin
    diff   = lane_a - lane_b;
    sign_a = lane_a[W-1];
    sign_b = lane_b[W-1];
    sign_r = diff[W-1];
    lane_flags.neg   = sign_r;
    lane_flags.zero  = ~|diff;
    lane_flags.carry = cmpf_carry(sign_a, sign_b, sign_r);
    lane_flags.ovf   = cmpf_ovf(sign_a, sign_b, sign_r);
  end

endmodule

// File: rtl/cmpf_stage.sv
module cmpf_stage #(
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stg_valid_in,
  input  logic [STATUS_W-1:0] stg_status_in,
  output logic                stg_valid_out,
  output logic [STATUS_W-1:0] stg_status_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_valid_out  <= 1'b0;
      stg_status_out <= '0;
    end else begin
      stg_valid_out <= stg_valid_in;
      if (stg_valid_in) stg_status_out <= stg_status_in;
    end
  end

endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
  import cmpf_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_wide,
  input  logic [DATA_W-1:0]   in_src_a,
  input  logic [DATA_W-1:0]   in_src_b,
  output logic                out_valid,
  output logic [STATUS_W-1:0] out_status
);

  localparam int NUM_LANES = 2;
  localparam int PAD_W     = STATUS_W - CMPF_FLAG_W;

  cmpf_flags_t               lane_flags [NUM_LANES];
  cmpf_flags_t               sel_flags;
  logic [STATUS_W-1:0]       next_status;

  // Lane 0 compares the low halves; lane 1 compares full words.
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : DATA_W;
    cmpf_lane #(.W(LW)) u_lane (
      .lane_a     (in_src_a[LW-1:0]),
      .lane_b     (in_src_b[LW-1:0]),
      .lane_flags (lane_flags[g])
    );
  end

  always_comb begin
    sel_flags   = in_wide ? lane_flags[1] : lane_flags[0];
    next_status = {sel_flags, {PAD_W{1'b0}}};
  end

  cmpf_stage #(.STATUS_W(STATUS_W)) u_stage (
    .clk            (clk),
    .rst            (rst),
    .stg_valid_in   (in_valid),
    .stg_status_in  (next_status),
    .stg_valid_out  (out_valid),
    .stg_status_out (out_status)
  );

endmodule

// File: rtl/cmp_flag_unit_checker.sv
module cmp_flag_unit_checker #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int STATUS_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_wide,
  input logic [DATA_W-1:0]   in_src_a,
  input logic [DATA_W-1:0]   in_src_b,
  input logic                out_valid,
  input logic [STATUS_W-1:0] out_status
);

  localparam int BN = STATUS_W - 1;
  localparam int BZ = STATUS_W - 2;
  localparam int BC = STATUS_W - 3;
  localparam int BV = STATUS_W - 4;

  // Reference flags from widened unsigned and sign-extended differences.
  // R8: narrow mode uses only low halves; R10: wide mode uses full words.
  logic [NARROW_W:0] n_uns, n_sgn;
  logic [DATA_W:0]   w_uns, w_sgn;
  logic              ref_n, ref_z, ref_c, ref_v;

  always_comb begin
    n_uns = {1'b0, in_src_a[NARROW_W-1:0]} - {1'b0, in_src_b[NARROW_W-1:0]};
    n_sgn = {in_src_a[NARROW_W-1], in_src_a[NARROW_W-1:0]}
          - {in_src_b[NARROW_W-1], in_src_b[NARROW_W-1:0]};
    w_uns = {1'b0, in_src_a} - {1'b0, in_src_b};
    w_sgn = {in_src_a[DATA_W-1], in_src_a} - {in_src_b[DATA_W-1], in_src_b};
    if (in_wide) begin
      ref_n = w_sgn[DATA_W-1];
      ref_z = (in_src_a == in_src_b);
      ref_c = ~w_uns[DATA_W];
      ref_v = w_sgn[DATA_W] ^ w_sgn[DATA_W-1];
    end else begin
      ref_n = n_sgn[NARROW_W-1];
      ref_z = (in_src_a[NARROW_W-1:0] == in_src_b[NARROW_W-1:0]);
      ref_c = ~n_uns[NARROW_W];
      ref_v = n_sgn[NARROW_W] ^ n_sgn[NARROW_W-1];
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_status == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r3_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    out_status[BV-1:0] == '0);

  a_r4_zero_flag: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_status[BZ] == $past(ref_z));

  a_r5_negative_flag: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_status[BN] == $past(ref_n));

  a_r6_overflow_flag: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_status[BV] == $past(ref_v));

  a_r7_carry_flag: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_status[BC] == $past(ref_c));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_status));

endmodule

bind cmp_flag_unit cmp_flag_unit_checker #(
  .DATA_W   (DATA_W),
  .NARROW_W (NARROW_W),
  .STATUS_W (STATUS_W)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_wide    (in_wide),
  .in_src_a   (in_src_a),
  .in_src_b   (in_src_b),
  .out_valid  (out_valid),
  .out_status (out_status)
);

// File: tb/cmp_flag_unit_tb.sv
`timescale 1ns/1ps
module cmp_flag_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_wide = 1'b0;
  logic [63:0] in_src_a = '0;
  logic [63:0] in_src_b = '0;
  logic        out_valid;
  logic [31:0] out_status;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] exp_status = '0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cmp_flag_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide),
    .in_src_a(in_src_a), .in_src_b(in_src_b),
    .out_valid(out_valid), .out_status(out_status)
  );

  // Behavioural model: carry as unsigned >=, overflow from a wider signed difference.
  function automatic logic [31:0] model(bit wide, logic [63:0] a, logic [63:0] b);
    bit n, z, c, v;
    longint sa, sb, r;
    logic signed [64:0] r64;
    if (wide) begin
      r64 = $signed({a[63], a}) - $signed({b[63], b});
      n = r64[63];
      z = (a == b);
      c = (a >= b);
      v = (r64[64] != r64[63]);
    end else begin
      sa = longint'($signed(a[31:0]));
      sb = longint'($signed(b[31:0]));
      r  = sa - sb;
      n  = r[31];
      z  = (a[31:0] == b[31:0]);
      c  = (a[31:0] >= b[31:0]);
      v  = (r > 64'sd2147483647) || (r < -64'sd2147483648);
    end
    return {n, z, c, v, 28'h0};
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle, then compare every output field with the model.
  task automatic step(bit v, bit wide, logic [63:0] a, logic [63:0] b, string tag);
    in_valid = v; in_wide = wide; in_src_a = a; in_src_b = b;
    @(posedge clk);
    #1;
    if (v) exp_status = model(wide, a, b);
    check(out_valid == v, {"R2 valid ", tag}, 64'(out_valid), 64'(v));
    check(out_status[27:0] == 28'h0, {"R3 low bits ", tag}, 64'(out_status[27:0]), 64'h0);
    check(out_status[31] == exp_status[31], {"R5 N ", tag}, 64'(out_status), 64'(exp_status));
    check(out_status[30] == exp_status[30], {"R4 Z ", tag}, 64'(out_status), 64'(exp_status));
    check(out_status[29] == exp_status[29], {"R7 C ", tag}, 64'(out_status), 64'(exp_status));
    check(out_status[28] == exp_status[28], {"R6 V ", tag}, 64'(out_status), 64'(exp_status));
    if (!v) check(out_status == exp_status, {"R9 hold ", tag}, 64'(out_status), 64'(exp_status));
  endtask

  task automatic do_reset(bit v_during);
    rst = 1'b1; in_valid = v_during; in_src_a = 64'h5; in_src_b = 64'h5;
    @(posedge clk);
    #1;
    exp_status = '0;
    check(out_valid == 1'b0, "R1 valid after reset", 64'(out_valid), 64'h0);
    check(out_status == 32'h0, "R1 status after reset", 64'(out_status), 64'h0);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    do_reset(1'b0);
    // Narrow mode corners (R8): upper halves are junk and must not matter.
    step(1, 0, 64'hDEAD_BEEF_0000_0007, 64'h1234_5678_0000_0007, "R8 equal low");
    step(1, 0, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_0000_0001, "R8 min minus one");
    step(1, 0, 64'h0000_0000_7FFF_FFFF, 64'hAAAA_AAAA_FFFF_FFFF, "R8 max minus -1");
    step(1, 0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, "R8 zero minus one");
    step(1, 0, 64'h0000_0001_0000_0003, 64'h0000_0000_0000_0003, "R8 upper differs");
    // Idle cycles with changing inputs (R9).
    step(0, 1, 64'h1, 64'h2, "R9 idle wide");
    step(0, 0, 64'hFFFF, 64'h0, "R9 idle narrow");
    // Wide mode corners (R10).
    step(1, 1, 64'h0000_0001_0000_0003, 64'h0000_0000_0000_0003, "R10 upper differs");
    step(1, 1, 64'h8000_0000_0000_0000, 64'h1, "R10 min minus one");
    step(1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R10 max minus -1");
    step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R10 equal");
    step(1, 1, 64'h0, 64'h8000_0000_0000_0000, "R10 zero minus min");
    // Back-to-back requests flipping width on every request.
    for (int i = 0; i < 400; i++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = (i % 7 == 0) ? ra : {$urandom, $urandom};
      if (i % 5 == 0) rb[63] = ~ra[63];
      step(1, i[0], ra, rb, i[0] ? "R10 random" : "R8 random");
      if (i % 13 == 0) step(0, ~i[0], rb, ra, "R9 random idle");
    end
    // Reset colliding with a request (R1).
    step(1, 1, 64'h3, 64'h9, "R7 before reset");
    do_reset(1'b1);
    step(1, 0, 64'h9, 64'h3, "R2 after reset");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule